// File: doc/BRIEF.md
# Page-Mode Asynchronous Flash Read Controller

This block sits on the host side of an asynchronous parallel flash that has page-mode reads. A client gives it one word address at a time over a valid/ready handshake. The controller drives the flash chip select, output enable, write enable and address lines. It holds output enable low for a number of clock cycles, samples the data bus on the last of those cycles, and returns the word as a one-cycle response pulse.

The controller keeps track of the page that is currently open. A page is 8 words. Word-address bits 3 and up name the page, and bits 2..0 pick the word inside it. A request that lands in the open page while chip select is still held low uses the short in-page wait count. Any other request uses the full wait count. That covers the first read after reset, a read to a different page, and a read after chip select was released. If the controller sits idle for a programmable number of cycles, it lets chip select go high. This ends page mode and forgets the open page. Both wait counts and the idle limit are inputs given in clock cycles.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, `flash_cs_n` and `flash_oe_n` are high, `rsp_valid` is low and no page is open, so the first read uses the full wait count.
- R2: `flash_we_n` stays high in every cycle.
- R3: A request that misses the open page, or that arrives while no page is open, holds `flash_oe_n` low for exactly `full_wait` cycles, starting the cycle after acceptance.
- R4: A request whose address bits [AW-1:3] equal the open page, made while `flash_cs_n` is still low, holds `flash_oe_n` low for exactly `page_wait` cycles.
- R5: `rsp_valid` is high for exactly one cycle: the cycle after the last low cycle of `flash_oe_n`. `rsp_data` then equals the value on `flash_dq` during that last low cycle.
- R6: `req_ready` is low from the cycle after acceptance until the response cycle. While it is low, `req_valid` and `req_addr` have no effect, so only one access is outstanding.
- R7: After a response with `idle_limit` = L > 0, if no request is accepted in the L following cycles, `flash_cs_n` goes high after those L cycles and the open page is forgotten. The next read then uses the full wait count.
- R8: With `idle_limit` = 0, `flash_cs_n` goes high in the response cycle itself, so every read uses the full wait count.
- R9: During an access, `flash_cs_n` and `flash_oe_n` are low and `flash_addr` holds the accepted address. Outside an access, `flash_oe_n` is high.
- R10: A wait count of 0 is treated as 1, so `flash_oe_n` stays low for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_wait | input | CW | Cycles of output enable for a random or first access |
| page_wait | input | CW | Cycles of output enable for an in-page access |
| idle_limit | input | IW | Idle cycles before chip select is released |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW | Word address of the request |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_data | output | DW | Read data |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, always high |
| flash_addr | output | AW | Flash word address |
| flash_dq | input | DW | Flash data bus, high-impedance while output enable is high |

## Verification
The assertions check the signal relations that must hold in every cycle. Output enable is only low while chip select is low. The address does not move while output enable is low. The response is a single pulse that follows the close of output enable. Ready is low during an access. Releasing chip select drops the page tag, and the wait counter counts down one step per cycle. Only the bench scenarios can show which wait count is chosen. Those scenarios cover a miss versus a hit, the idle release and its effect on the next access, the zero idle limit, the zero wait count, and ignoring requests during a busy access. The bench checks these against a cycle model and against the data bus value for the address.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    // Word-select bits inside one page (8 words per page)
    localparam int unsigned WORD_SEL_BITS = 3;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } rd_state_e;

    // Cycles to hold output enable low: a zero request counts as one
    function automatic int unsigned eff_wait(input int unsigned req);
        return (req == 0) ? 1 : req;
    endfunction

endpackage

// File: rtl/pflash_page_tag.sv
module pflash_page_tag #(
    parameter int unsigned TW = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [TW-1:0] set_page,
    input  logic          clr_en,
    input  logic [TW-1:0] query_page,
    output logic          hit,
    output logic          tag_valid
);
    logic [TW-1:0] tag_q;
    logic          valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (clr_en) begin
            valid_q <= 1'b0;
        end else if (set_en) begin
            valid_q <= 1'b1;
            tag_q   <= set_page;
        end
    end

    assign tag_valid = valid_q;
    assign hit       = valid_q && (tag_q == query_page);

    AST_CLR_DROPS_TAG: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !tag_valid); // R7

    AST_SET_OPENS_TAG: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> (tag_valid && tag_q == $past(set_page))); // R4

endmodule

// File: rtl/pflash_wait_cnt.sv
module pflash_wait_cnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/pflash_idle_timer.sv
module pflash_idle_timer #(
    parameter int unsigned IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tick,
    input  logic [IW-1:0] limit,
    output logic          expire
);
    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= {{(IW-1){1'b0}}, 1'b1};
        end else if (tick && cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = tick && (cnt_q >= limit);

    AST_IDLE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !start) |=> (cnt_q >= $past(cnt_q))); // R7

endmodule

// File: rtl/pflash_rd_ctrl.sv
module pflash_rd_ctrl
    import pflash_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 8,
    parameter int unsigned IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] full_wait,
    input  logic [CW-1:0] page_wait,
    input  logic [IW-1:0] idle_limit,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          flash_cs_n,
    output logic          flash_oe_n,
    output logic          flash_we_n,
    output logic [AW-1:0] flash_addr,
    input  logic [DW-1:0] flash_dq
);
    localparam int unsigned TW = AW - WORD_SEL_BITS;

    rd_state_e     state_q;
    logic [AW-1:0] addr_q;
    logic          cs_n_q;
    logic          oe_n_q;
    logic          rv_q;
    logic [DW-1:0] rd_q;

    logic          accept;
    logic          busy;
    logic          done;
    logic          cnt_zero;
    logic          page_hit;
    logic          page_open;
    logic          idle_tick;
    logic          idle_expire;
    logic          release_cs;
    logic [CW-1:0] wait_sel;

    assign busy      = (state_q == ST_ACCESS);
    assign accept    = req_valid && !busy;
    assign done      = busy && cnt_zero;
    assign wait_sel  = page_hit ? page_wait : full_wait;
    assign idle_tick = !busy && !cs_n_q && !req_valid;
    assign release_cs = (done && idle_limit == '0) || idle_expire;

    pflash_page_tag #(.TW(TW)) u_tag (
        .clk        (clk),
        .rst        (rst),
        .set_en     (done),
        .set_page   (addr_q[AW-1:WORD_SEL_BITS]),
        .clr_en     (release_cs),
        .query_page (req_addr[AW-1:WORD_SEL_BITS]),
        .hit        (page_hit),
        .tag_valid  (page_open)
    );

    pflash_wait_cnt #(.CW(CW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (wait_sel),
        .run      (busy),
        .zero     (cnt_zero)
    );

    pflash_idle_timer #(.IW(IW)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .start  (done),
        .tick   (idle_tick),
        .limit  (idle_limit),
        .expire (idle_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cs_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            rv_q    <= 1'b0;
            rd_q    <= '0;
        end else begin
            rv_q <= 1'b0;
            if (accept) begin
                state_q <= ST_ACCESS;
                addr_q  <= req_addr;
                cs_n_q  <= 1'b0;
                oe_n_q  <= 1'b0;
            end else if (done) begin
                state_q <= ST_IDLE;
                oe_n_q  <= 1'b1;
                rv_q    <= 1'b1;
                rd_q    <= flash_dq;
                if (release_cs) cs_n_q <= 1'b1;
            end else if (release_cs) begin
                cs_n_q <= 1'b1;
            end
        end
    end

    assign req_ready  = !busy;
    assign rsp_valid  = rv_q;
    assign rsp_data   = rd_q;
    assign flash_cs_n = cs_n_q;
    assign flash_oe_n = oe_n_q;
    assign flash_we_n = 1'b1;
    assign flash_addr = addr_q;

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !flash_oe_n |-> !flash_cs_n); // R9

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!flash_oe_n && !$past(flash_oe_n)) |-> $stable(flash_addr)); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !flash_oe_n |-> !req_ready); // R6

    AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R5

    AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (flash_oe_n && !$past(flash_oe_n))); // R5

    AST_CS_RISE_CLOSES_PAGE: assert property (@(posedge clk) disable iff (rst)
        $rose(flash_cs_n) |-> !page_open); // R7

endmodule

// File: tb/pflash_rd_ctrl_bench.sv
module pflash_rd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    full_wait = 8'd5;
    logic [7:0]    page_wait = 8'd2;
    logic [7:0]    idle_limit = 8'd4;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rsp_valid, flash_cs_n, flash_oe_n, flash_we_n;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] flash_addr;
    wire  [DW-1:0] flash_dq;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string scn = "R1";

    function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
        return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'hC3A5;
    endfunction

    // behavioural flash responder
    assign flash_dq = flash_oe_n ? 'z : fdat(flash_addr);

    pflash_rd_ctrl u_pflash_rd_ctrl (
        .clk(clk), .rst(rst), .full_wait(full_wait), .page_wait(page_wait),
        .idle_limit(idle_limit), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .flash_cs_n(flash_cs_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .flash_addr(flash_addr), .flash_dq(flash_dq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // cycle reference model
    bit          m_busy, m_cs, m_pvalid, m_rv;
    int          m_left, m_idle;
    logic [AW-1:0] m_addr;
    logic [AW-4:0] m_page;
    logic [DW-1:0] m_rd;

    always @(posedge clk) begin
        m_rv = 1'b0;
        if (rst) begin
            m_busy = 0; m_cs = 0; m_pvalid = 0; m_idle = 0; m_left = 0; m_addr = '0;
        end else if (m_busy) begin
            if (m_left <= 1) begin
                m_busy = 0; m_rv = 1; m_rd = fdat(m_addr);
                m_pvalid = 1; m_page = m_addr[AW-1:3]; m_idle = 1;
                if (idle_limit == 0) begin m_cs = 0; m_pvalid = 0; end
            end else m_left = m_left - 1;
        end else if (req_valid) begin
            int n;
            n = (m_pvalid && m_cs && m_page == req_addr[AW-1:3]) ? int'(page_wait) : int'(full_wait);
            m_left = (n < 1) ? 1 : n;
            m_busy = 1; m_cs = 1; m_addr = req_addr;
        end else if (m_cs) begin
            if (m_idle >= int'(idle_limit)) begin m_cs = 0; m_pvalid = 0; end
            else m_idle = m_idle + 1;
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at cycle %0d", rq, scn, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        chk("R6", "req_ready", req_ready, !m_busy);
        chk("R7", "flash_cs_n", flash_cs_n, !m_cs);
        chk("R3", "flash_oe_n", flash_oe_n, !m_busy);
        chk("R2", "flash_we_n", flash_we_n, 1);
        chk("R5", "rsp_valid", rsp_valid, m_rv);
        if (m_rv) chk("R5", "rsp_data", rsp_data, m_rd);
        if (m_cs) chk("R9", "flash_addr", flash_addr, m_addr);
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            finish_run();
        end
    end

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: first read after reset takes the full wait
        scn = "R1"; rd(24'h000100);
        // R4: in-page hits, then a miss (R3)
        scn = "R4"; rd(24'h000103); rd(24'h000107);
        scn = "R3"; rd(24'h000108); rd(24'h00010F);
        // R7: idle past the limit releases chip select; next read full
        scn = "R7"; idle(8); rd(24'h000109);
        scn = "R4"; idle(2); rd(24'h00010A);
        // R10: zero wait counts behave as one cycle
        scn = "R10"; page_wait = 8'd0; rd(24'h00010B);
        full_wait = 8'd0; rd(24'h000200); rd(24'h000300);
        full_wait = 8'd6; page_wait = 8'd3;
        // R6: request held while busy with a different address is ignored
        scn = "R6";
        @(negedge clk); req_valid = 1'b1; req_addr = 24'h000400;
        @(negedge clk); req_addr = 24'h0ABCDE;
        idle(3); req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        // R8: zero idle limit, every read full
        scn = "R8"; idle_limit = 8'd0;
        rd(24'h000401); rd(24'h000402); idle(2); rd(24'h000403);
        // mixed pattern
        scn = "R4"; idle_limit = 8'd3; lf = 32'h1234;
        for (int i = 0; i < 60; i++) begin
            lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
            rd({14'd0, lf[9:8], 5'd0, lf[2:0]} | 24'h001000);
            idle(lf[12:10] % 6);
        end
        idle(10);
        finish_run();
    end
endmodule